// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a serial bit stream into parallel characters. It watches one serial input line. Its timing comes from a one-cycle enable that pulses at sixteen times the bit rate. A character starts on a high-to-low transition of the line. The block checks the start bit again at mid-bit, so a short dip is rejected and not taken as a character. It then samples each data bit at its midpoint, least significant bit first. It can also take a parity bit, and it checks the first stop bit.

Four run-time settings control the character shape:

- data length, 7 or 8 bits;
- parity enable;
- parity sense, odd or even;
- stop count, 1 or 2.

The settings are captured when a character starts, so a change takes effect on the next character. A shift stage assembles the character. A holding register stores the finished one, so the host has a whole character time to read it. The host reads by pulsing a read-acknowledge input. Four flags report status: data ready, parity error, framing error and overrun.

Top module: `async_rx_core`

## Requirements
- R1: After a synchronous reset, `rx_byte` is 0x00 and `rx_ready`, `err_parity`, `err_frame` and `err_overrun` are all 0.
- R2: A character begins only on a high-to-low transition of `rxd`. The line is sampled again 8 ticks later. If it is high at that point, nothing is received and the receiver goes back to waiting for the next falling edge.
- R3: With `cfg_len8`=1, eight data bits follow the start bit, least significant bit first. Each is sampled every 16 ticks, and they appear unchanged in `rx_byte[7:0]`.
- R4: With `cfg_len8`=0, seven data bits are received into `rx_byte[6:0]`, and `rx_byte[7]` reads 0.
- R5: With `cfg_par_en`=1, one parity bit follows the last data bit. The parity check covers the data bits and the parity bit together:
  - with `cfg_par_odd`=0, their XOR must be 0;
  - with `cfg_par_odd`=1, their XOR must be 1.
  If it is not, `err_parity` is set with the character.
- R6: `err_frame` is set when the first stop bit is sampled low. In 2-stop mode (`cfg_stop2`=1), the second stop bit is never checked.
- R7: `rx_ready` rises when a character completes. A one-cycle `rd_ack` pulse clears `rx_ready`, `err_parity`, `err_frame` and `err_overrun`.
- R8: If a character completes while `rx_ready` is 1 and `rd_ack` is not pulsed in that cycle, then:
  - `err_overrun` is set;
  - `rx_byte` keeps the older character;
  - the error flags of the older character are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_ack | input | 1 | Host read pulse, clears ready and all flags |
| rx_byte | output | 8 | Holding register contents |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | First stop bit of the held character was low |
| err_overrun | output | 1 | A character was lost because the holding register was full |

## Verification
The main function is swept over all twelve framing combinations (length × parity mode × stop count), with sixteen byte values in each, including 0x00 and 0xFF. This separates a bit-order or bit-count fault from a parity or stop-count fault.

Directed frames are then sent:
- frames with the parity bit flipped, under both parity senses, which catches an inverted parity sense;
- frames with a low first stop bit, and frames with a low second stop bit, which separates the checked stop position from the ignored one;
- a short start dip, which shows that glitch rejection and a clean return to idle both work;
- two unread characters in a row, which shows that the older byte is kept and overrun is reported.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int DATA_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic len_full;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    // Shift stage fills from the top; a short character sits one place high.
    function automatic logic [DATA_W-1:0] align_char(
        input logic [DATA_W-1:0] sh,
        input logic              len_full
    );
        return len_full ? sh : (sh >> 1);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import async_rx_pkg::*;
#(
    parameter int OVS = OVERSAMPLE,
    parameter int DW  = DATA_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  frame_cfg_t cfg,
    output logic       done,
    output rx_char_t   chr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DW);
    localparam int MID   = OVS / 2;

    rx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DW-1:0]     sh;
    logic              par_acc;
    logic              pe_q;
    logic              prev;

    logic              at_mid;
    logic              at_bit;
    logic [IDX_W-1:0]  last_idx;

    assign at_mid   = (cnt == CNT_W'(MID - 1));
    assign at_bit   = (cnt == CNT_W'(OVS - 1));
    assign last_idx = cfg_q.len_full ? IDX_W'(DW - 1) : IDX_W'(DW - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            cnt     <= '0;
            bit_idx <= '0;
            sh      <= '0;
            par_acc <= 1'b0;
            pe_q    <= 1'b0;
            prev    <= 1'b1;
            done    <= 1'b0;
            chr     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev <= rx;
                case (state)
                    ST_IDLE: begin
                        if (prev && !rx) begin
                            state <= ST_START;
                            cnt   <= '0;
                            cfg_q <= cfg;
                        end
                    end
                    ST_START: begin
                        if (at_mid) begin
                            cnt <= '0;
                            if (rx) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                par_acc <= 1'b0;
                                pe_q    <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_bit) begin
                            cnt     <= '0;
                            sh      <= {rx, sh[DW-1:1]};
                            par_acc <= par_acc ^ rx;
                            if (bit_idx == last_idx)
                                state <= cfg_q.par_en ? ST_PAR : ST_STOP1;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_bit) begin
                            cnt   <= '0;
                            pe_q  <= par_acc ^ rx ^ cfg_q.par_odd;
                            state <= ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (at_bit) begin
                            cnt          <= '0;
                            done         <= 1'b1;
                            chr.data     <= align_char(sh, cfg_q.len_full);
                            chr.par_err  <= pe_q;
                            chr.frm_err  <= !rx;
                            state        <= cfg_q.stop2 ? ST_STOP2 : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_bit) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && at_mid && rx) |=> (state == ST_IDLE)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_START_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(tick && prev && !rx)) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
    import async_rx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  rx_char_t      chr,
    input  logic          rd_ack,
    input  logic          len_full,
    output logic [DW-1:0] data_q,
    output logic          ready_q,
    output logic          pe_q,
    output logic          fe_q,
    output logic          ovr_q
);
    logic take;
    assign take = done && (!ready_q || rd_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            pe_q    <= 1'b0;
            fe_q    <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (take) begin
            data_q  <= chr.data;
            ready_q <= 1'b1;
            pe_q    <= chr.par_err;
            fe_q    <= chr.frm_err;
            ovr_q   <= 1'b0;
        end else if (done) begin
            ovr_q   <= 1'b1;
        end else if (rd_ack) begin
            ready_q <= 1'b0;
            pe_q    <= 1'b0;
            fe_q    <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

    AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
        (done && ready_q && !rd_ack) |=> ($stable(data_q) && ovr_q)); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !done) |=> (!ready_q && !pe_q && !fe_q && !ovr_q)); // R7

    AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && !len_full) |-> (chr.data[DW-1] == 1'b0)); // R4

    AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        (pe_q || fe_q || ovr_q) |-> ready_q); // R5

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    logic       rx_s;
    logic       chr_done;
    rx_char_t   chr;
    frame_cfg_t cfg;

    assign cfg.len_full = cfg_len8;
    assign cfg.par_en   = cfg_par_en;
    assign cfg.par_odd  = cfg_par_odd;
    assign cfg.stop2    = cfg_stop2;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    rx_framer #(.OVS(OVERSAMPLE), .DW(DATA_W)) u_framer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick16),
        .rx   (rx_s),
        .cfg  (cfg),
        .done (chr_done),
        .chr  (chr)
    );

    rx_hold_reg #(.DW(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .done     (chr_done),
        .chr      (chr),
        .rd_ack   (rd_ack),
        .len_full (u_framer.cfg_q.len_full),
        .data_q   (rx_byte),
        .ready_q  (rx_ready),
        .pe_q     (err_parity),
        .fe_q     (err_frame),
        .ovr_q    (err_overrun)
    );

endmodule

// File: tb/async_rx_core_tb_top.sv
module async_rx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_ready, err_parity, err_frame, err_overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    async_rx_core dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
        .rd_ack(rd_ack), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int ticks);
        rxd = v;
        repeat (2 * ticks) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] b, input logic flip_par,
                             input logic stop1_v, input logic stop2_v);
        logic [7:0] d;
        logic       p;
        d = cfg_len8 ? b : {1'b0, b[6:0]};
        hold_line(1'b0, 16);
        for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) hold_line(b[i], 16);
        if (cfg_par_en) begin
            p = (^d) ^ cfg_par_odd ^ flip_par;
            hold_line(p, 16);
        end
        hold_line(stop1_v, 16);
        if (cfg_stop2) hold_line(stop2_v, 16);
        hold_line(1'b1, 6);
    endtask

    task automatic host_read();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 byte", rx_byte, 8'h00);
        chk("R1 ready", rx_ready, 0);
        chk("R1 parity", err_parity, 0);
        chk("R1 frame", err_frame, 0);
        chk("R1 overrun", err_overrun, 0);
        hold_line(1'b1, 20);

        // R3 R4 R5 R6 R7: sweep all framing combinations
        for (int c = 0; c < 12; c++) begin
            cfg_len8    = c[0];
            cfg_stop2   = c[1];
            cfg_par_en  = (c / 4) != 0;
            cfg_par_odd = (c / 4) == 2;
            for (int k = 0; k < 16; k++) begin
                logic [7:0] b;
                logic [7:0] e;
                b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37 + c * 11 + 5));
                e = cfg_len8 ? b : {1'b0, b[6:0]};
                send_char(b, 1'b0, 1'b1, 1'b1);
                chk(cfg_len8 ? "R3 data" : "R4 data", rx_byte, e);
                chk("R7 ready set", rx_ready, 1);
                chk("R5 no parity error", err_parity, 0);
                chk("R6 no frame error", err_frame, 0);
                chk("R8 no overrun", err_overrun, 0);
                host_read();
                chk("R7 ready cleared", rx_ready, 0);
            end
        end

        // R5: flipped parity bit, both senses
        for (int s = 0; s < 2; s++) begin
            cfg_len8 = 1; cfg_stop2 = 0; cfg_par_en = 1; cfg_par_odd = s[0];
            send_char(8'h5A, 1'b1, 1'b1, 1'b1);
            chk("R5 parity error", err_parity, 1);
            chk("R5 data kept", rx_byte, 8'h5A);
            host_read();
            chk("R7 parity cleared", err_parity, 0);
        end

        // R6: low first stop bit, 1 and 2 stop modes
        cfg_par_en = 0; cfg_par_odd = 0;
        for (int s = 0; s < 2; s++) begin
            cfg_stop2 = s[0];
            send_char(8'hC3, 1'b0, 1'b0, 1'b1);
            chk("R6 frame error", err_frame, 1);
            chk("R6 data", rx_byte, 8'hC3);
            host_read();
            chk("R7 frame cleared", err_frame, 0);
        end
        // R6: low second stop bit is not checked
        cfg_stop2 = 1;
        send_char(8'h3C, 1'b0, 1'b1, 1'b0);
        chk("R6 second stop ignored", err_frame, 0);
        chk("R6 data", rx_byte, 8'h3C);
        host_read();

        // R2: short start dip is rejected, next frame still received
        cfg_stop2 = 0;
        hold_line(1'b0, 4);
        hold_line(1'b1, 40);
        chk("R2 glitch ignored", rx_ready, 0);
        send_char(8'h81, 1'b0, 1'b1, 1'b1);
        chk("R2 after glitch", rx_byte, 8'h81);
        chk("R2 ready after glitch", rx_ready, 1);
        host_read();

        // R8: overrun keeps the older character
        send_char(8'h11, 1'b0, 1'b1, 1'b1);
        send_char(8'h22, 1'b0, 1'b1, 1'b1);
        chk("R8 overrun set", err_overrun, 1);
        chk("R8 old data kept", rx_byte, 8'h11);
        chk("R8 still ready", rx_ready, 1);
        host_read();
        chk("R7 overrun cleared", err_overrun, 0);
        chk("R7 ready cleared", rx_ready, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule